// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a small serial memory on a two-wire bus. The host drives the clock line (SCL) and shares an open-drain data line (SDA) with the slave. Both lines are brought into a fast system clock domain through synchronisers. The slave finds start and stop conditions by watching SDA move while SCL is high. It shifts 8-bit words in and out and answers on the ninth clock with an acknowledge. Behind the bus logic sit a register-array memory with a registered read port, a write-cycle timer and a standby flag.

A write transaction carries the slave address with the direction bit low, a word address and one data byte. The data byte is stored when the stop arrives. A write cycle of a parameterised length follows, and while it runs the slave refuses its own address. A read transaction returns bytes starting at the current pointer. Each low acknowledge from the host asks for the next byte. A missing acknowledge ends the read, and the slave then leaves the bus alone until the next start. A random read is done by sending a word address in write direction, then a repeated start, then the address byte in read direction.

The slave only pulls SDA low and never drives it high. Standby is reported after reset, and again after a stop once no write cycle is running.

Top module: `twm_slave`

## Requirements
- R1: While reset is held and on the cycle after it, `sda_drive_low_o` is 0, `standby_o` is 1 and `write_busy_o` is 0.
- R2: A start is SDA falling while SCL is high. It begins a transaction and clears `standby_o`. Bits clocked before any start are ignored: the slave does not acknowledge them and standby stays set.
- R3: The first byte after a start is the address byte, sent MSB first. Bits 7..1 must equal `DEV_ADDR` (default 7'h50), and bit 0 is 1 for read and 0 for write. On a match the slave pulls SDA low during the ninth clock. On a mismatch it does not acknowledge, and it stays off the bus until the next start.
- R4: In a write, the word address byte is acknowledged and its low log2(DEPTH) bits select the location. The first data byte after it is acknowledged. Any further data byte in the same transaction is not acknowledged and is not stored.
- R5: A stop that follows an acknowledged data byte stores that byte and starts a write cycle. For the whole write cycle, about `WR_CYCLES` system clocks, `write_busy_o` is 1. During the cycle a matching address byte is not acknowledged.
- R6: In a read, the slave sends the byte at the current pointer, MSB first. It changes its SDA drive only while SCL is low. A word address written just before a repeated start sets the pointer.
- R7: Every byte the slave sends advances the pointer by one, wrapping from DEPTH-1 to 0. A low acknowledge from the host makes the slave send the next byte. A read that begins without a word address continues from the pointer.
- R8: After a read byte that the host does not acknowledge (SDA high on the ninth clock), the slave releases SDA. It does not drive SDA again until the next start.
- R9: `standby_o` returns to 1 only after a stop, and only once no write cycle is running. It stays 0 after a missing host acknowledge until the stop arrives, and it is never 1 while `write_busy_o` is 1.
- R10: A repeated start that arrives before a stop discards the pending data byte. Nothing is stored and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock from the host, asynchronous |
| sda_i | input | 1 | Sensed level of the shared data line, asynchronous |
| sda_drive_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| standby_o | output | 1 | Slave idle after a stop with no write cycle running |
| write_busy_o | output | 1 | Internal write cycle in progress |

## Verification
The main function is tried four ways, and each one tells a different fault apart. A write to every one of the sixteen locations, each followed by a random read in reverse order, with data computed from the location, separates addressing faults from data-path faults. A sequential read that starts three locations before the top of the array and uses a host acknowledge on every byte but the last shows whether the pointer wraps and whether each acknowledge is honoured. A current-address read after that, with no word address, shows whether the pointer moved on each sent byte. The remaining patterns stress the protocol itself. Bytes clocked with no start, a wrong address, a second data byte, a repeated start over a pending write, an address sent during the write cycle, and clocking after a missing acknowledge must each leave memory and bus untouched. The length of each write cycle is measured in system clocks.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // off the bus until the next start
    ST_RX,     // shifting a byte in from the host
    ST_ACK,    // slave holding SDA low on the ninth clock
    ST_TX,     // shifting a byte out to the host
    ST_HACK    // sampling the host acknowledge of a sent byte
  } st_t;

  typedef enum logic [1:0] {
    PH_DEV,    // slave address plus direction
    PH_WADDR,  // word address of a write
    PH_DATA    // write data
  } ph_t;
endpackage

// File: rtl/twm_sync_edge.sv
module twm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  // Idle bus is high on both lines, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // SDA may only move with SCL high when marking a frame boundary.
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  // One synchronous write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twm_wr_timer.sv
module twm_wr_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (kick)         count <= CW'(CYCLES);
    else if (count != '0)  count <= count - 1'b1;
  end

  assign busy = (count != '0);
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         DEPTH       = 16,
  parameter int         WR_CYCLES   = 1000000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low_o,
  output logic standby_o,
  output logic write_busy_o
);
  import twm_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic busy, mem_we;
  logic [7:0] rdata;

  st_t        st;
  ph_t        ph;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       rw, ninth, host_ack;
  logic [AW-1:0] ptr, pend_addr;
  logic       pend_vld;
  logic [7:0] pend_data;
  logic       seen_stop, sda_oe;
  logic       fsm_idle;

  twm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  // The data byte is stored when the stop ends the write transaction.
  assign mem_we = stop_p & pend_vld;

  twm_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(pend_addr), .wdata(pend_data),
    .raddr(ptr), .rdata(rdata)
  );

  twm_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(mem_we), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_DEV;
      bit_cnt   <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      ninth     <= 1'b0;
      host_ack  <= 1'b0;
      ptr       <= '0;
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      seen_stop <= 1'b1;
      sda_oe    <= 1'b0;
    end else if (start_p) begin
      st        <= ST_RX;
      ph        <= PH_DEV;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      seen_stop <= 1'b0;
      pend_vld  <= 1'b0;
    end else if (stop_p) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      seen_stop <= 1'b1;
      pend_vld  <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            ninth   <= 1'b0;
            unique case (ph)
              PH_DEV: begin
                if (shreg[7:1] == DEV_ADDR && !busy) begin
                  st     <= ST_ACK;
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_WADDR: begin
                st     <= ST_ACK;
                sda_oe <= 1'b1;
                ptr    <= shreg[AW-1:0];
              end
              default: begin
                if (!pend_vld) begin
                  st        <= ST_ACK;
                  sda_oe    <= 1'b1;
                  pend_vld  <= 1'b1;
                  pend_data <= shreg;
                  pend_addr <= ptr;
                end else begin
                  st <= ST_IDLE;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            ninth <= 1'b1;
          end else if (scl_fall && ninth) begin
            bit_cnt <= '0;
            if (rw) begin
              st     <= ST_TX;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
            end else begin
              st     <= ST_RX;
              sda_oe <= 1'b0;
              ph     <= (ph == PH_DEV) ? PH_WADDR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              st     <= ST_HACK;
              sda_oe <= 1'b0;
              ninth  <= 1'b0;
              ptr    <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
            ninth    <= 1'b1;
          end else if (scl_fall && ninth) begin
            if (host_ack) begin
              st      <= ST_TX;
              shreg   <= rdata;
              sda_oe  <= ~rdata[7];
              bit_cnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      standby_o    <= 1'b1;
      write_busy_o <= 1'b0;
    end else begin
      standby_o    <= seen_stop & ~busy;
      write_busy_o <= busy;
    end
  end

  assign sda_drive_low_o = sda_oe;
  assign fsm_idle        = (st == ST_IDLE);
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_drive_low_o,
  input logic standby_o,
  input logic write_busy_o,
  input logic start_p,
  input logic seen_stop,
  input logic fsm_idle
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (standby_o && !sda_drive_low_o && !write_busy_o));

  // R2
  a_r2_start_leaves_standby: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !seen_stop);

  // R6
  a_r6_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low_o) |-> !scl_i);

  // R8
  a_r8_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    fsm_idle |-> !sda_drive_low_o);

  // R9
  a_r9_busy_hides_standby: assert property (@(posedge clk) disable iff (rst)
    write_busy_o |-> !standby_o);
endmodule

bind twm_slave twm_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i),
  .sda_drive_low_o(sda_drive_low_o), .standby_o(standby_o),
  .write_busy_o(write_busy_o), .start_p(start_p),
  .seen_stop(seen_stop), .fsm_idle(fsm_idle)
);

// File: tb/twm_slave_tb.sv
module twm_slave_tb;
  localparam logic [6:0] DEV = 7'h50;
  localparam int DEPTH = 16;
  localparam int WR    = 600;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_line;
  logic dut_low, standby, wbusy;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int stop_cyc = 0;
  bit done = 0;
  logic [7:0] exp_mem [DEPTH];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = !(host_low || dut_low);

  twm_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(dut_low), .standby_o(standby), .write_busy_o(wbusy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    host_low = !b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic bit_in(output bit b);
    host_low = 0; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!ack);
  endtask

  task automatic bus_start();
    host_low = 0; wq(); scl = 1; wq(); host_low = 1; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    host_low = 1; wq(); scl = 1; wq(); host_low = 0; stop_cyc = cyc; wq();
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (wbusy && n < 4 * WR) begin @(negedge clk); n++; end
    chk(req, int'(wbusy), 0);
  endtask

  task automatic rd_random(input int a, output logic [7:0] d);
    bit k;
    bus_start();
    send_byte({DEV, 1'b0}, k); chk("R6 dev write ack", k, 1);
    send_byte(8'(a), k);       chk("R6 word addr ack", k, 1);
    bus_start();
    send_byte({DEV, 1'b1}, k); chk("R6 dev read ack", k, 1);
    recv_byte(0, d);
    bus_stop();
  endtask

  initial begin
    bit k;
    logic [7:0] d;
    int dur;
    repeat (5) @(negedge clk);
    chk("R1 drive in reset", int'(dut_low), 0);
    chk("R1 standby in reset", int'(standby), 1);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1 drive", int'(dut_low), 0);
    chk("R1 standby", int'(standby), 1);
    chk("R1 busy", int'(wbusy), 0);

    // R2: bits without a start are ignored
    scl = 0; wq();
    send_byte({DEV, 1'b0}, k);
    chk("R2 no ack without start", k, 0);
    chk("R2 standby kept", int'(standby), 1);

    // R3: wrong address, then more bits
    bus_start();
    chk("R2 standby cleared by start", int'(standby), 0);
    send_byte({DEV ^ 7'h01, 1'b0}, k);
    chk("R3 wrong address no ack", k, 0);
    send_byte(8'h00, k);
    chk("R3 off bus after mismatch", k, 0);
    bus_stop();
    chk("R9 standby after stop", int'(standby), 1);

    // R4/R5: write every location
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'((a * 29 + 7) ^ (a << 4));
      bus_start();
      send_byte({DEV, 1'b0}, k); chk("R3 address ack", k, 1);
      send_byte(8'(a), k);       chk("R4 word addr ack", k, 1);
      send_byte(d, k);           chk("R4 data ack", k, 1);
      bus_stop();
      dur = stop_cyc;
      chk("R5 busy after stop", int'(wbusy), 1);
      chk("R9 no standby while busy", int'(standby), 0);
      if (a == 0) begin
        bus_start();
        send_byte({DEV, 1'b1}, k);
        chk("R5 no address ack while busy", k, 0);
        bus_stop();
      end
      while (wbusy && cyc - stop_cyc < 4 * WR) @(negedge clk);
      dur = cyc - dur;
      chk("R5 write cycle length in window", int'(dur >= WR && dur <= WR + 8), 1);
      chk("R9 standby after write cycle", int'(standby), 1);
      exp_mem[a] = d;
    end

    // R6: random read of each location, reverse order
    for (int a = DEPTH - 1; a >= 0; a--) begin
      rd_random(a, d);
      chk("R6 random read data", int'(d), int'(exp_mem[a]));
    end

    // R7: sequential read across the wrap
    bus_start();
    send_byte({DEV, 1'b0}, k);
    send_byte(8'(DEPTH - 3), k);
    bus_start();
    send_byte({DEV, 1'b1}, k); chk("R7 dev read ack", k, 1);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, d);
      chk("R7 sequential data", int'(d), int'(exp_mem[(DEPTH - 3 + i) % DEPTH]));
    end
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, k); chk("R7 current read ack", k, 1);
    recv_byte(0, d);
    chk("R7 current address data", int'(d), int'(exp_mem[(DEPTH - 3 + 8) % DEPTH]));

    // R8/R9: after missing host ack
    chk("R8 released after nack", int'(dut_low), 0);
    send_byte({DEV, 1'b1}, k);
    chk("R8 silent until start", k, 0);
    chk("R8 no drive after clocks", int'(dut_low), 0);
    chk("R9 no standby before stop", int'(standby), 0);
    bus_stop();
    chk("R9 standby after read stop", int'(standby), 1);

    // R4: second data byte refused
    bus_start();
    send_byte({DEV, 1'b0}, k);
    send_byte(8'd3, k);
    send_byte(8'h5A, k); chk("R4 first data ack", k, 1);
    send_byte(8'hC3, k); chk("R4 second data no ack", k, 0);
    bus_stop();
    wait_idle("R5 busy ends");
    exp_mem[3] = 8'h5A;
    rd_random(3, d); chk("R4 first data stored", int'(d), 8'h5A);
    rd_random(4, d); chk("R4 neighbour untouched", int'(d), int'(exp_mem[4]));

    // R10: repeated start over a pending write
    bus_start();
    send_byte({DEV, 1'b0}, k);
    send_byte(8'd7, k);
    send_byte(8'h11, k); chk("R10 data ack", k, 1);
    bus_start();
    send_byte({DEV, 1'b1}, k); chk("R10 read ack", k, 1);
    recv_byte(0, d);
    chk("R10 old data read", int'(d), int'(exp_mem[7]));
    bus_stop();
    chk("R10 no write cycle", int'(wbusy), 0);
    rd_random(7, d);
    chk("R10 location unchanged", int'(d), int'(exp_mem[7]));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule